// File: doc/BRIEF.md
# CAN Controller Mode Sequencer

This block sequences the operating modes of a CAN controller. Software requests come in as a configuration request level and as set and clear pulses for a power-down request bit. The block returns acknowledge status for both and reports its current mode. While the block waits to power down it watches the transmit engine's busy flag and its end-of-frame outcome pulses. When asleep, it watches the receive line for any dominant level, which signals a wakeup. Before it rejoins the bus, it counts recessive bits on an external bit-time strobe.

The five states are CONFIG, ACTIVE, DRAIN, SLEEP and RESYNC.

- Reset enters CONFIG.
- CONFIG to SLEEP: the power-down request is set. This has priority.
- CONFIG to ACTIVE: the configuration request is low.
- ACTIVE to CONFIG: the configuration request is high. This has priority.
- ACTIVE to DRAIN: a power-down request arrives while a frame is in flight.
- ACTIVE to SLEEP: a power-down request arrives and no frame is in flight.
- DRAIN to SLEEP: the frame ends with success, lost arbitration or a bus error.
- DRAIN to ACTIVE: software withdraws the power-down request.
- SLEEP to RESYNC: auto-wakeup sees a dominant level, or software clears the request.
- RESYNC to ACTIVE: the run of recessive bits is complete.
- RESYNC to SLEEP: the power-down request is set again.
- RESYNC to CONFIG: the configuration request is set.

In SLEEP the power-down acknowledge also drives the clock-gate request. The wakeup flag is sticky. The block has no error counters, so leaving sleep leaves them unchanged.

Top module: `can_mode_seq`

## Requirements
- R1: After reset, mode_o is 0 (CONFIG), cfg_ack_o is 1, and pd_req_o, pd_ack_o, clk_gate_o and wake_flag_o are 0. The mode encoding is CONFIG=0, ACTIVE=1, DRAIN=2, SLEEP=3 and RESYNC=4.
- R2: In CONFIG with cfg_req_i low, mode_o is ACTIVE and cfg_ack_o is 0 one clock later. In ACTIVE with cfg_req_i high, mode_o is CONFIG and cfg_ack_o is 1 one clock later.
- R3: A pd_set_i pulse makes pd_req_o 1 one clock later. In ACTIVE with tx_busy_i low, pd_ack_o and clk_gate_o become 1 one clock after that (mode SLEEP).
- R4: In ACTIVE with tx_busy_i high, a power-down request moves the block to DRAIN with pd_ack_o held at 0. pd_ack_o becomes 1 one clock after a pulse on tx_ok_i, tx_lost_i or tx_err_i.
- R5: A power-down request seen in CONFIG is acknowledged one clock later, even with tx_busy_i high.
- R6: In SLEEP, a receive level of 0 (dominant; 1 is recessive) lasting a single clock sets wake_flag_o one clock later. No filtering is applied. The flag stays 1 until a wake_clr_i pulse clears it one clock later.
- R7: With wake_auto_i high, a dominant sample in SLEEP clears pd_req_o and pd_ack_o one clock later, and the block enters RESYNC.
- R8: With wake_auto_i low, a dominant sample in SLEEP leaves the block in SLEEP. After a pd_clr_i pulse clears pd_req_o, the block enters RESYNC on the next clock with pd_ack_o at 0.
- R9: In RESYNC, each bit_stb_i pulse with rx_i at 1 counts one recessive bit, and a pulse with rx_i at 0 restarts the count at zero. The clock after the 11th consecutive recessive strobe, mode_o becomes ACTIVE.
- R10: A dominant receive level outside SLEEP leaves wake_flag_o at 0.
- R11: In DRAIN, clearing the power-down request returns the block to ACTIVE without ever raising pd_ack_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_req_i | input | 1 | Configuration request level |
| pd_set_i | input | 1 | Pulse that sets the power-down request |
| pd_clr_i | input | 1 | Pulse that clears the power-down request |
| wake_auto_i | input | 1 | Auto-wakeup on bus activity enable |
| wake_clr_i | input | 1 | Pulse that clears the wakeup flag |
| rx_i | input | 1 | Receive line, 1 recessive, 0 dominant |
| bit_stb_i | input | 1 | One-clock strobe per bit time |
| tx_busy_i | input | 1 | A frame is being transmitted |
| tx_ok_i | input | 1 | Frame ended successfully (pulse) |
| tx_lost_i | input | 1 | Frame lost arbitration (pulse) |
| tx_err_i | input | 1 | Frame ended in bus error (pulse) |
| cfg_ack_o | output | 1 | Configuration acknowledged |
| pd_req_o | output | 1 | Power-down request bit |
| pd_ack_o | output | 1 | Power-down acknowledged |
| clk_gate_o | output | 1 | Request to gate the controller clock |
| wake_flag_o | output | 1 | Sticky wakeup interrupt flag |
| mode_o | output | 3 | Current mode encoding |

## Verification
The hardest situation to reach is the exact end of the recessive-bit count in RESYNC after a restart. The stimulus first wakes the block from SLEEP. It then feeds a few recessive strobes, one dominant strobe and exactly ten more recessive strobes, and checks that the mode is still RESYNC. It then gives one more strobe and checks the mode one clock later. The power-down drain is reached by holding tx_busy_i high through the request and ending the frame with different outcome pulses.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;
    typedef enum logic [2:0] {
        ST_CONFIG = 3'd0,
        ST_ACTIVE = 3'd1,
        ST_DRAIN  = 3'd2,
        ST_SLEEP  = 3'd3,
        ST_RESYNC = 3'd4
    } mode_e;
endpackage

// File: rtl/cms_pd_req_reg.sv
module cms_pd_req_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic auto_clr_i,
    output logic req_o
);
    logic req_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          req_q <= 1'b0;
        else if (auto_clr_i) req_q <= 1'b0;
        else if (set_i)      req_q <= 1'b1;
        else if (clr_i)      req_q <= 1'b0;
    end

    assign req_o = req_q;

    assert_auto_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        auto_clr_i |=> !req_q);
endmodule

// File: rtl/cms_wake_flag.sv
module cms_wake_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic sleeping_i,
    input  logic rx_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  flag_q <= 1'b0;
        else if (sleeping_i && !rx_i) flag_q <= 1'b1;
        else if (clr_i)              flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    assert_wake_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sleeping_i && !rx_i) |=> flag_q);
    assert_wake_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);
    assert_no_wake_awake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_q && !sleeping_i) |=> !flag_q);
endmodule

// File: rtl/cms_idle_counter.sv
module cms_idle_counter #(
    parameter int IDLE_BITS = 11
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic stb_i,
    input  logic rx_i,
    output logic done_o
);
    localparam int CW = $clog2(IDLE_BITS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_BITS);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (clear_i)      cnt_q <= '0;
        else if (stb_i) begin
            if (!rx_i)             cnt_q <= '0;
            else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done_o = (cnt_q == LIMIT);

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LIMIT);
    assert_dominant_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stb_i && !rx_i) |=> (cnt_q == '0));
endmodule

// File: rtl/cms_mode_fsm.sv
module cms_mode_fsm
    import can_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_req_i,
    input  logic       pd_req_i,
    input  logic       wake_auto_i,
    input  logic       rx_i,
    input  logic       tx_busy_i,
    input  logic       tx_end_i,
    input  logic       idle_done_i,
    output logic       cfg_ack_o,
    output logic       pd_ack_o,
    output logic       sleeping_o,
    output logic       resync_o,
    output logic       auto_wake_o,
    output logic [2:0] mode_o
);
    mode_e state_q, state_n;

    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_CONFIG: begin
                if (pd_req_i)        state_n = ST_SLEEP;
                else if (!cfg_req_i) state_n = ST_ACTIVE;
            end
            ST_ACTIVE: begin
                if (cfg_req_i)       state_n = ST_CONFIG;
                else if (pd_req_i)   state_n = tx_busy_i ? ST_DRAIN : ST_SLEEP;
            end
            ST_DRAIN: begin
                if (!pd_req_i)       state_n = ST_ACTIVE;
                else if (tx_end_i)   state_n = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (wake_auto_i && !rx_i) state_n = ST_RESYNC;
                else if (!pd_req_i)       state_n = ST_RESYNC;
            end
            ST_RESYNC: begin
                if (cfg_req_i)        state_n = ST_CONFIG;
                else if (pd_req_i)    state_n = ST_SLEEP;
                else if (idle_done_i) state_n = ST_ACTIVE;
            end
            default:                  state_n = ST_CONFIG;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_CONFIG;
        else        state_q <= state_n;
    end

    always_comb begin
        cfg_ack_o   = (state_q == ST_CONFIG);
        pd_ack_o    = (state_q == ST_SLEEP);
        sleeping_o  = (state_q == ST_SLEEP);
        resync_o    = (state_q == ST_RESYNC);
        auto_wake_o = (state_q == ST_SLEEP) && wake_auto_i && !rx_i;
        mode_o      = state_q;
    end

    assert_ack_waits_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pd_ack_o) |-> ($past(tx_end_i) || !$past(tx_busy_i) ||
                             ($past(state_q) == ST_CONFIG) || ($past(state_q) == ST_RESYNC)));
    assert_resync_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state_q) == ST_RESYNC && state_q == ST_ACTIVE) |-> $past(idle_done_i));
    assert_cfg_pd_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONFIG && pd_req_i) |=> pd_ack_o);
    assert_drain_cancel_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DRAIN && !pd_req_i) |=> (state_q == ST_ACTIVE));
endmodule

// File: rtl/can_mode_seq.sv
module can_mode_seq #(
    parameter int IDLE_BITS = 11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_req_i,
    input  logic       pd_set_i,
    input  logic       pd_clr_i,
    input  logic       wake_auto_i,
    input  logic       wake_clr_i,
    input  logic       rx_i,
    input  logic       bit_stb_i,
    input  logic       tx_busy_i,
    input  logic       tx_ok_i,
    input  logic       tx_lost_i,
    input  logic       tx_err_i,
    output logic       cfg_ack_o,
    output logic       pd_req_o,
    output logic       pd_ack_o,
    output logic       clk_gate_o,
    output logic       wake_flag_o,
    output logic [2:0] mode_o
);
    logic pd_req, auto_wake, sleeping, resync, idle_done, tx_end;

    assign tx_end = tx_ok_i | tx_lost_i | tx_err_i;

    cms_pd_req_reg u_pd_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (pd_set_i),
        .clr_i      (pd_clr_i),
        .auto_clr_i (auto_wake),
        .req_o      (pd_req)
    );

    cms_wake_flag u_wake (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleeping_i (sleeping),
        .rx_i       (rx_i),
        .clr_i      (wake_clr_i),
        .flag_o     (wake_flag_o)
    );

    cms_idle_counter #(.IDLE_BITS(IDLE_BITS)) u_idle (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (!resync),
        .stb_i   (bit_stb_i),
        .rx_i    (rx_i),
        .done_o  (idle_done)
    );

    cms_mode_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_req_i   (cfg_req_i),
        .pd_req_i    (pd_req),
        .wake_auto_i (wake_auto_i),
        .rx_i        (rx_i),
        .tx_busy_i   (tx_busy_i),
        .tx_end_i    (tx_end),
        .idle_done_i (idle_done),
        .cfg_ack_o   (cfg_ack_o),
        .pd_ack_o    (pd_ack_o),
        .sleeping_o  (sleeping),
        .resync_o    (resync),
        .auto_wake_o (auto_wake),
        .mode_o      (mode_o)
    );

    assign pd_req_o   = pd_req;
    assign clk_gate_o = pd_ack_o;

    assert_gate_only_asleep_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_gate_o |-> (pd_req_o || $past(pd_req_o)));
endmodule

// File: tb/tb_can_mode_seq.sv
module tb_can_mode_seq;
    localparam int CLK_PERIOD = 10;
    localparam logic [2:0] M_CFG = 3'd0, M_ACT = 3'd1, M_DRN = 3'd2, M_SLP = 3'd3, M_RSY = 3'd4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_req = 1'b1, pd_set = 1'b0, pd_clr = 1'b0, wake_auto = 1'b0, wake_clr = 1'b0;
    logic rx = 1'b1, stb = 1'b0, tx_busy = 1'b0, tx_ok = 1'b0, tx_lost = 1'b0, tx_err = 1'b0;
    logic cfg_ack, pd_req, pd_ack, clk_gate, wake_flag;
    logic [2:0] mode;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_mode_seq dut (
        .clk(clk), .rst_n(rst_n), .cfg_req_i(cfg_req), .pd_set_i(pd_set), .pd_clr_i(pd_clr),
        .wake_auto_i(wake_auto), .wake_clr_i(wake_clr), .rx_i(rx), .bit_stb_i(stb),
        .tx_busy_i(tx_busy), .tx_ok_i(tx_ok), .tx_lost_i(tx_lost), .tx_err_i(tx_err),
        .cfg_ack_o(cfg_ack), .pd_req_o(pd_req), .pd_ack_o(pd_ack), .clk_gate_o(clk_gate),
        .wake_flag_o(wake_flag), .mode_o(mode)
    );

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_set();  pd_set = 1'b1;   tick(1); pd_set = 1'b0;   endtask
    task automatic pulse_clr();  pd_clr = 1'b1;   tick(1); pd_clr = 1'b0;   endtask
    task automatic pulse_wclr(); wake_clr = 1'b1; tick(1); wake_clr = 1'b0; endtask

    task automatic strobe(input logic v);
        stb = 1'b1; rx = v; tick(1); stb = 1'b0; rx = 1'b1;
    endtask

    task automatic resync_to_active();
        for (int i = 0; i < 11; i++) strobe(1'b1);
        tick(1);
        chk("R9", "mode after 11 recessive", mode, M_ACT);
    endtask

    task automatic t_reset();
        chk("R1", "mode", mode, M_CFG);
        chk("R1", "cfg_ack", cfg_ack, 1);
        chk("R1", "pd_req", pd_req, 0);
        chk("R1", "pd_ack", pd_ack, 0);
        chk("R1", "clk_gate", clk_gate, 0);
        chk("R1", "wake_flag", wake_flag, 0);
    endtask

    task automatic t_config();
        cfg_req = 1'b0; tick(1);
        chk("R2", "mode after cfg clear", mode, M_ACT);
        chk("R2", "cfg_ack low", cfg_ack, 0);
        cfg_req = 1'b1; tick(1);
        chk("R2", "mode after cfg set", mode, M_CFG);
        chk("R2", "cfg_ack high", cfg_ack, 1);
        cfg_req = 1'b0; tick(1);
    endtask

    task automatic t_rx_awake();
        rx = 1'b0; tick(3); rx = 1'b1;
        chk("R10", "wake_flag while active", wake_flag, 0);
    endtask

    task automatic t_pd_sw_exit();
        wake_auto = 1'b0;
        pulse_set();
        chk("R3", "pd_req", pd_req, 1);
        chk("R3", "pd_ack not yet", pd_ack, 0);
        tick(1);
        chk("R3", "pd_ack", pd_ack, 1);
        chk("R3", "clk_gate", clk_gate, 1);
        rx = 1'b0; tick(1); rx = 1'b1;
        chk("R6", "wake_flag one-clock dominant", wake_flag, 1);
        chk("R8", "still asleep", mode, M_SLP);
        tick(3);
        chk("R6", "wake_flag sticky", wake_flag, 1);
        pulse_wclr();
        chk("R6", "wake_flag cleared", wake_flag, 0);
        pulse_clr();
        chk("R8", "pd_req cleared", pd_req, 0);
        tick(1);
        chk("R8", "mode resync", mode, M_RSY);
        chk("R8", "pd_ack low", pd_ack, 0);
        for (int i = 0; i < 5; i++) strobe(1'b1);
        strobe(1'b0);
        for (int i = 0; i < 10; i++) strobe(1'b1);
        tick(1);
        chk("R9", "restart: still resync after 10", mode, M_RSY);
        strobe(1'b1);
        chk("R9", "still resync on 11th edge", mode, M_RSY);
        tick(1);
        chk("R9", "active after restart count", mode, M_ACT);
    endtask

    task automatic t_pd_auto();
        wake_auto = 1'b1;
        pulse_set(); tick(1);
        chk("R3", "asleep", mode, M_SLP);
        rx = 1'b0; tick(1);
        chk("R7", "pd_req auto clear", pd_req, 0);
        chk("R7", "pd_ack clear", pd_ack, 0);
        chk("R7", "mode resync", mode, M_RSY);
        chk("R6", "wake flag", wake_flag, 1);
        tick(2); rx = 1'b1;
        pulse_wclr();
        resync_to_active();
        wake_auto = 1'b0;
    endtask

    task automatic t_drain(input int kind);
        tx_busy = 1'b1;
        pulse_set(); tick(1);
        chk("R4", "mode drain", mode, M_DRN);
        tick(4);
        chk("R4", "ack held while busy", pd_ack, 0);
        case (kind)
            0: tx_ok = 1'b1;
            1: tx_lost = 1'b1;
            default: tx_err = 1'b1;
        endcase
        tx_busy = 1'b0;
        tick(1);
        tx_ok = 1'b0; tx_lost = 1'b0; tx_err = 1'b0;
        chk("R4", $sformatf("ack after end kind %0d", kind), pd_ack, 1);
        pulse_clr(); tick(1);
        resync_to_active();
    endtask

    task automatic t_drain_cancel();
        tx_busy = 1'b1;
        pulse_set(); tick(1);
        chk("R11", "mode drain", mode, M_DRN);
        pulse_clr();
        tick(1);
        chk("R11", "back to active", mode, M_ACT);
        chk("R11", "no ack", pd_ack, 0);
        tx_busy = 1'b0;
    endtask

    task automatic t_cfg_pd();
        cfg_req = 1'b1; tick(1);
        tx_busy = 1'b1;
        pulse_set(); tick(1);
        chk("R5", "ack in config", pd_ack, 1);
        tx_busy = 1'b0;
    endtask

    initial begin
        tick(2);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_config();
        t_rx_awake();
        t_pd_sw_exit();
        t_pd_auto();
        t_drain(0);
        t_drain(1);
        t_drain(2);
        t_drain_cancel();
        t_cfg_pd();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual %0d expected below 20000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
                $finish;
            end
        end
    end
endmodule